// File: doc/BRIEF.md
# Clock Failure Fallback Controller

This block runs from a base clock that is always present and watches an external oscillator input. The oscillator input is brought into the base-clock domain through a two-flop synchroniser, and its rising edges are detected there. Supervision begins at the first edge seen after reset. If the gap between edges grows past a parameterised number of base-clock cycles, the block moves the CPU clock selection from the oscillator to the base clock and raises a sticky unlock interrupt flag.

The mode input chooses the form of the fallback clock. In direct mode the base clock is used as it is. In prescaled mode it is divided by two, and a one-in-two clock enable is produced for that purpose, so no derived clock is ever generated.

The fallback does not undo itself. Oscillator edges that come back leave the selection on the base clock. Only a hardware reset request held for at least `MIN_RST` base cycles sends the selection back to the oscillator, and it also clears the flag. A shorter request changes nothing. A separate active-low asynchronous reset initialises the whole block at power-up.

Top module: `clkfb_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `clk_sel` is 2'b00 (oscillator), `unlock_irq` is 0 and `div2_en` is 0.
- R2: Supervision starts at the first synchronised rising edge after reset or re-arm. If rising edges arrive at most `TIMEOUT` base cycles apart, the selection stays at 2'b00. If no edge arrives for more than `TIMEOUT` cycles, the block enters fallback.
- R3: In fallback, `clk_sel` is 2'b01 (base clock, undivided) when `presc_mode`=0 and 2'b10 (base clock divided by two) when `presc_mode`=1.
- R4: Oscillator edges that resume after a fallback do not return `clk_sel` to 2'b00.
- R5: `unlock_irq` becomes 1 in the same cycle that the selection first leaves 2'b00.
- R6: While `clk_sel` is 2'b10, `div2_en` is 1 on exactly one of every two consecutive cycles. In every other case it is 0.
- R7: `unlock_irq` stays 1 until `flag_clr` is sampled high. A clear in the same cycle as a failure event leaves the flag set, and clearing the flag does not change `clk_sel`.
- R8: `hw_rst` held high for at least `MIN_RST` consecutive cycles returns `clk_sel` to 2'b00 and clears `unlock_irq` on the cycle after release. A shorter pulse changes neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Always-running base clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously |
| osc_in | input | 1 | External oscillator input (asynchronous) |
| hw_rst | input | 1 | Hardware reset request, level, synchronous to clk_base |
| presc_mode | input | 1 | 1 = divided-by-two fallback, 0 = direct fallback |
| flag_clr | input | 1 | Strobe that clears the unlock flag |
| clk_sel | output | 2 | Clock select: 00 oscillator, 01 base, 10 base/2 |
| div2_en | output | 1 | One-in-two clock enable in prescaled fallback |
| unlock_irq | output | 1 | Sticky unlock interrupt request |

## Verification
The oscillator is run as a square wave for every period from 2 base cycles up to three beyond the timeout, in both modes. These runs place the exact period at which supervision trips and show which fallback code each mode produces. Each healthy run then stops the oscillator and restarts it, which separates a sticky fallback from one that recovers by itself. Reset requests one cycle short of and exactly at the minimum length, together with a clear held across a failure, test the re-arm threshold and the priority of setting the flag over clearing it.

// File: rtl/clkfb_pkg.sv
package clkfb_pkg;
  typedef enum logic [1:0] {
    SEL_OSC  = 2'b00,
    SEL_BASE = 2'b01,
    SEL_DIV2 = 2'b10
  } clk_sel_e;
endpackage

// File: rtl/clkfb_osc_sync.sv
// Two-flop synchroniser plus rising-edge detector for the oscillator input.
module clkfb_osc_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_async,
  output logic rise
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= osc_async;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/clkfb_gap_mon.sv
// Counts base cycles since the last oscillator edge; flags a missing edge.
module clkfb_gap_mon #(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic watch_en,
  input  logic restart,
  output logic fail
);
  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_limit;

  assign at_limit = (cnt_q == LAST);
  assign fail     = watch_en & armed_q & ~rise & at_limit;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (restart) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (rise) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (watch_en && armed_q && !at_limit) begin
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/clkfb_rst_qual.sv
// Measures the hardware reset request; pulses rearm on release of a long one.
module clkfb_rst_qual #(
  parameter int MIN_RST = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_rst,
  output logic rearm
);
  localparam int RW = $clog2(MIN_RST + 1);
  localparam logic [RW-1:0] FULL = RW'(MIN_RST);

  logic [RW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!hw_rst)            cnt_d = '0;
    else if (cnt_q == FULL) cnt_d = cnt_q;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign rearm = ~hw_rst & (cnt_q == FULL);
endmodule

// File: rtl/clkfb_ctrl.sv
module clkfb_ctrl
  import clkfb_pkg::*;
#(
  parameter int TIMEOUT = 16,
  parameter int MIN_RST = 1000
) (
  input  logic       clk_base,
  input  logic       rst_n,
  input  logic       osc_in,
  input  logic       hw_rst,
  input  logic       presc_mode,
  input  logic       flag_clr,
  output logic [1:0] clk_sel,
  output logic       div2_en,
  output logic       unlock_irq
);
  logic rise, fail_evt, rearm, watch_en;
  logic fb_q, fb_d, flag_q, flag_d, phase_q, phase_d;
  clk_sel_e sel;

  clkfb_osc_sync u_sync (
    .clk(clk_base), .rst_n(rst_n), .osc_async(osc_in), .rise(rise)
  );

  assign watch_en = ~fb_q & ~hw_rst;

  clkfb_gap_mon #(.TIMEOUT(TIMEOUT)) u_gap (
    .clk(clk_base), .rst_n(rst_n), .rise(rise), .watch_en(watch_en),
    .restart(rearm), .fail(fail_evt)
  );

  clkfb_rst_qual #(.MIN_RST(MIN_RST)) u_rq (
    .clk(clk_base), .rst_n(rst_n), .hw_rst(hw_rst), .rearm(rearm)
  );

  // Next state: rearm wins, then a failure event, then a software clear.
  always_comb begin
    fb_d    = fb_q;
    flag_d  = flag_q;
    phase_d = fb_q ? ~phase_q : 1'b0;
    if (rearm) begin
      fb_d    = 1'b0;
      flag_d  = 1'b0;
      phase_d = 1'b0;
    end else if (fail_evt) begin
      fb_d    = 1'b1;
      flag_d  = 1'b1;
    end else if (flag_clr) begin
      flag_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_base or negedge rst_n) begin
    if (!rst_n) begin
      fb_q    <= 1'b0;
      flag_q  <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      fb_q    <= fb_d;
      flag_q  <= flag_d;
      phase_q <= phase_d;
    end
  end

  always_comb begin
    if (!fb_q)          sel = SEL_OSC;
    else if (presc_mode) sel = SEL_DIV2;
    else                sel = SEL_BASE;
  end

  assign clk_sel    = sel;
  assign div2_en    = fb_q & presc_mode & phase_q;
  assign unlock_irq = flag_q;
endmodule

// File: rtl/clkfb_ctrl_chk.sv
module clkfb_ctrl_chk (
  input logic       clk_base,
  input logic       rst_n,
  input logic       flag_clr,
  input logic [1:0] clk_sel,
  input logic       div2_en,
  input logic       unlock_irq,
  input logic       fail_evt,
  input logic       rearm
);
  a_r4_fallback_sticky: assert property (@(posedge clk_base) disable iff (!rst_n)
    (clk_sel != 2'b00 && !rearm) |=> (clk_sel != 2'b00));

  a_r5_flag_on_fail: assert property (@(posedge clk_base) disable iff (!rst_n)
    fail_evt |=> (unlock_irq && clk_sel != 2'b00));

  a_r6_div2_alternates: assert property (@(posedge clk_base) disable iff (!rst_n)
    div2_en |=> !div2_en);

  a_r6_div2_only_prescaled: assert property (@(posedge clk_base) disable iff (!rst_n)
    div2_en |-> (clk_sel == 2'b10));

  a_r7_flag_holds: assert property (@(posedge clk_base) disable iff (!rst_n)
    (unlock_irq && !flag_clr && !rearm) |=> unlock_irq);

  a_r8_rearm_restores: assert property (@(posedge clk_base) disable iff (!rst_n)
    rearm |=> (clk_sel == 2'b00 && !unlock_irq));
endmodule

bind clkfb_ctrl clkfb_ctrl_chk u_chk (
  .clk_base(clk_base), .rst_n(rst_n), .flag_clr(flag_clr), .clk_sel(clk_sel),
  .div2_en(div2_en), .unlock_irq(unlock_irq), .fail_evt(fail_evt), .rearm(rearm)
);

// File: tb/sim_clkfb_ctrl.sv
module sim_clkfb_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TO   = 8;
  localparam int MINR = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0, osc_in = 1'b0, hw_rst = 1'b0, presc_mode = 1'b0, flag_clr = 1'b0;
  logic [1:0] clk_sel;
  logic div2_en, unlock_irq;
  int osc_per = 0;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkfb_ctrl #(.TIMEOUT(TO), .MIN_RST(MINR)) u0 (
    .clk_base(clk), .rst_n(rst_n), .osc_in(osc_in), .hw_rst(hw_rst),
    .presc_mode(presc_mode), .flag_clr(flag_clr), .clk_sel(clk_sel),
    .div2_en(div2_en), .unlock_irq(unlock_irq)
  );

  // Oscillator model: square wave with a period of osc_per base cycles.
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (osc_per == 0) begin
        osc_in = 1'b0;
        ph = 0;
      end else begin
        ph = (ph + 1) % osc_per;
        osc_in = (ph < osc_per / 2);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sample;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic por;
    @(negedge clk);
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int fb_code;
    int d0, d1;
    // R1: reset state
    tick(2);
    #1;
    chk("R1 sel in reset", clk_sel, 0);
    chk("R1 flag in reset", unlock_irq, 0);
    chk("R1 div2 in reset", div2_en, 0);

    for (int m = 0; m < 2; m++) begin
      for (int p = 2; p <= TO + 3; p++) begin
        @(negedge clk);
        presc_mode = m[0];
        osc_per = p;
        por();
        tick(8 * p + 20);
        sample();
        fb_code = (p > TO) ? (m == 1 ? 2 : 1) : 0;
        chk("R2/R3 sel after run", clk_sel, fb_code);
        chk("R5 flag after run", unlock_irq, (p > TO) ? 1 : 0);
        if (p <= TO) begin
          @(negedge clk);
          osc_per = 0;
          tick(TO + 10);
          sample();
          chk("R2/R3 sel after stop", clk_sel, m == 1 ? 2 : 1);
          chk("R5 flag after stop", unlock_irq, 1);
          @(negedge clk);
          osc_per = p;
          tick(6 * p + 10);
          sample();
          chk("R4 sel after resume", clk_sel, m == 1 ? 2 : 1);
        end
        sample(); d0 = int'(div2_en);
        sample(); d1 = int'(div2_en);
        chk("R6 div2 ones per pair", d0 + d1, m);
      end
    end

    // R7: clear behaviour (presently in prescaled fallback)
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    sample();
    chk("R7 flag cleared", unlock_irq, 0);
    chk("R7 sel kept on clear", clk_sel, 2);

    // R8: short reset request has no effect
    @(negedge clk);
    osc_per = 4;
    hw_rst = 1'b1;
    tick(MINR - 1);
    hw_rst = 1'b0;
    tick(5);
    sample();
    chk("R8 short reset sel", clk_sel, 2);
    chk("R8 short reset flag", unlock_irq, 0);

    // R8: qualified reset re-arms; running oscillator keeps selection
    @(negedge clk);
    flag_clr = 1'b0;
    hw_rst = 1'b1;
    tick(MINR);
    hw_rst = 1'b0;
    tick(40);
    sample();
    chk("R8 long reset sel", clk_sel, 0);
    chk("R8 long reset flag", unlock_irq, 0);
    chk("R6 div2 off at osc", div2_en, 0);

    // R7: clear held across a failure event; set wins
    @(negedge clk);
    flag_clr = 1'b1;
    osc_per = 0;
    begin
      int seen = 0;
      for (int i = 0; i < 60 && seen == 0; i++) begin
        sample();
        if (clk_sel != 2'b00) begin
          seen = 1;
          chk("R7 set wins over clear", unlock_irq, 1);
        end
      end
      chk("R5 failure seen", seen, 1);
    end
    sample();
    chk("R7 held clear then clears", unlock_irq, 0);
    @(negedge clk);
    flag_clr = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule